// File: doc/BRIEF.md
# Redundant-State Modulator for a Split-Link Clamped Full Bridge

This block turns a requested phase voltage, one of five levels, into the eight gate commands of one winding's full bridge. The bridge is built from two three-level neutral-clamped legs fed from a DC link split by two series capacitors. Current is driven along one diagonal of the bridge. The source side ties the winding to the positive rail and the return side ties it to the negative rail. Each side is in one of three conditions: full (outer and inner switch on), clamp (inner switch only, winding tied to the midpoint) or off (current carried by the free-wheeling diodes). The excitation voltage in units of half the link is the sum of the two side values, with full = +1, clamp = 0 and off = -1.

The full-link levels can be made in only one way. Each half-link level and the zero level can be made in several ways, and the half-link states differ in which capacitor they charge or discharge. The block selects among these redundant states from the sign of the upper-minus-lower capacitor voltage error, with a deadband, and from the sensed current direction. A fault descriptor (switch index, open or short) removes the states the damaged switch can no longer produce. The block then falls back to an equivalent state, or flags degraded operation. With fault tolerance enabled, a fault on the normal diagonal moves the winding for good to the other diagonal, where it runs with inverted current. The current controller keeps issuing the same excitation levels.

Top module: `rsm_top`

## Requirements
- R1: A synchronous active-low reset drives all eight gates low, clears the degraded flag and the inverted-excitation flag, and sets the stored balance preference to "lower capacitor high".
- R2: Gates, degraded flag and excitation flag change only on a clock edge where the strobe input is high. The result appears on the outputs in the same edge.
- R3: Gate bit k drives switch k+1. Bits 0 to 3 form the left leg: outer-high, inner-high, inner-low, outer-low. Bits 4 to 7 form the right leg in the same order. In normal excitation the source side is bits 0 (outer) and 1 (inner) and the return side is bits 7 (outer) and 6 (inner). The level code is 3-bit two's complement: 010=+2, 001=+1, 000=0, 111=-1, 110=-2. Code 011 saturates to +2, and codes 100 and 101 saturate to -2. +2 sets both sides full and -2 turns both sides off.
- R4: For +1, a balance error above the deadband selects source full / return clamp (discharges upper), and an error below the negative deadband selects source clamp / return full. For -1, the same two cases select source off / return clamp (charges lower) and source clamp / return off.
- R5: While the error lies within plus or minus the deadband (8 by default, inclusive), the previous preference is kept.
- R6: When the sensed current direction differs from the excitation direction, the balancing choice of R4 is swapped. Normal excitation expects positive current and inverted excitation expects negative current.
- R7: Zero is produced by the first available of: clamp/clamp, source full / return off, source off / return full.
- R8: On an active side of the bridge, an open outer switch forbids full, an open inner switch forbids full and clamp, a shorted outer switch forbids clamp, and a shorted inner switch forbids off. Faults on switches of the idle diagonal forbid nothing.
- R9: If the preferred state is forbidden, an allowed state with the same voltage is used. If none exists, all gates go low and the degraded flag is set.
- R10: With fault tolerance enabled and a valid fault on switch 1, 2, 7 or 8, the inverted-excitation flag is set at that strobe and stays set until reset. From then on bits 0, 1, 6 and 7 stay low.
- R11: A fault on switch 3, 4, 5 or 6 never causes the move to inverted excitation.
- R12: In inverted excitation the source side is bits 4 (outer) and 5 (inner) and the return side is bits 3 (outer) and 2 (inner). The two diagonals are never driven together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_i | input | 1 | Modulation cycle strobe |
| lvl_i | input | 3 | Requested excitation level, two's complement |
| v_up_i | input | VW | Upper capacitor voltage |
| v_lo_i | input | VW | Lower capacitor voltage |
| cur_pos_i | input | 1 | Sensed winding current is positive |
| ft_en_i | input | 1 | Fault-tolerant reconfiguration enable |
| flt_vld_i | input | 1 | Fault descriptor valid |
| flt_idx_i | input | 3 | Faulty switch index (0 = switch 1) |
| flt_open_i | input | 1 | 1 = open fault, 0 = short fault |
| gate_o | output | 8 | Gate commands, bit k drives switch k+1 |
| degraded_o | output | 1 | Requested level not producible |
| exc_inv_o | output | 1 | Winding runs on the inverted diagonal |

## Verification
On every cycle the assertions check several properties: outputs hold between strobes; a degraded result leaves every gate low; the inverted flag never falls without reset and keeps the normal diagonal dark; the two diagonals are never on together; a full level always drives four switches; and the balance preference holds inside the deadband. Only the bench's scenarios can show that each error sign and current direction picks the intended redundant state. The same holds for the fallback order under each fault kind and the exact gate patterns of the inverted diagonal. Those need known capacitor voltages and fault sequences with hand-derived patterns.

// File: rtl/rsm_pkg.sv
// Shared types and switch placement for the redundant-state modulator.
// Assumes eight switches per winding, two three-level legs.
package rsm_pkg;

    localparam int NSW = 8;

    // Condition of one side (source or return) of the active diagonal
    typedef enum logic [1:0] {
        SIDE_OFF   = 2'd0,
        SIDE_CLAMP = 2'd1,
        SIDE_FULL  = 2'd2
    } side_e;

    // Which side conditions a possibly damaged side can still produce
    typedef struct packed {
        logic off_ok;
        logic clamp_ok;
        logic full_ok;
    } side_avail_t;

    // Switch positions (gate bit indices) for the normal diagonal
    localparam int unsigned N_SRC_OUT = 0;
    localparam int unsigned N_SRC_IN  = 1;
    localparam int unsigned N_RET_IN  = 6;
    localparam int unsigned N_RET_OUT = 7;
    // Switch positions for the inverted diagonal
    localparam int unsigned I_SRC_OUT = 4;
    localparam int unsigned I_SRC_IN  = 5;
    localparam int unsigned I_RET_IN  = 2;
    localparam int unsigned I_RET_OUT = 3;

    localparam logic [NSW-1:0] NORM_MASK = (NSW'(1) << N_SRC_OUT) | (NSW'(1) << N_SRC_IN)
                                         | (NSW'(1) << N_RET_IN)  | (NSW'(1) << N_RET_OUT);
    localparam logic [NSW-1:0] INV_MASK  = (NSW'(1) << I_SRC_OUT) | (NSW'(1) << I_SRC_IN)
                                         | (NSW'(1) << I_RET_IN)  | (NSW'(1) << I_RET_OUT);

    // True when the given side condition is still producible
    function automatic logic side_ok(input side_e s, input side_avail_t a);
        case (s)
            SIDE_OFF:   return a.off_ok;
            SIDE_CLAMP: return a.clamp_ok;
            SIDE_FULL:  return a.full_ok;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rsm_balance_pref.sv
// Capacitor balance preference with deadband.
// Computes upper-minus-lower error and remembers which capacitor was last
// seen high; inside the deadband the stored preference is reused.
// pref = 1 means the upper capacitor is high.
module rsm_balance_pref #(
    parameter int VW = 10,
    parameter int DB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_i,
    input  logic [VW-1:0] v_up_i,
    input  logic [VW-1:0] v_lo_i,
    output logic          pref_next_o
);
    localparam int EW = VW + 1;
    localparam logic signed [EW-1:0] DB_POS = EW'(DB);
    localparam logic signed [EW-1:0] DB_NEG = -DB_POS;

    logic signed [EW-1:0] err;
    logic                 pref_q;

    assign err = $signed({1'b0, v_up_i}) - $signed({1'b0, v_lo_i});

    // Decide the preference for this strobe, holding inside the band
    always_comb begin
        if (err > DB_POS)      pref_next_o = 1'b1;
        else if (err < DB_NEG) pref_next_o = 1'b0;
        else                   pref_next_o = pref_q;
    end

    // Store the preference on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     pref_q <= 1'b0;
        else if (stb_i) pref_q <= pref_next_o;
    end

    // R5: inside the deadband the stored preference does not move
    p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && err <= DB_POS && err >= DB_NEG) |=> (pref_q == $past(pref_q)));

endmodule

// File: rtl/rsm_polarity.sv
// Excitation polarity latch.
// Moves the winding to the inverted diagonal when fault tolerance is
// enabled and a fault is reported on a normal-diagonal switch; only reset
// returns it. Assumes the fault index is 0-based switch number.
module rsm_polarity
    import rsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic       ft_en_i,
    input  logic       flt_vld_i,
    input  logic [2:0] flt_idx_i,
    output logic       inv_next_o,
    output logic       inv_q_o
);
    logic on_norm;

    // Fault lies on the normal diagonal
    assign on_norm = NORM_MASK[flt_idx_i];

    // Polarity to use at this strobe
    assign inv_next_o = inv_q_o | (ft_en_i & flt_vld_i & on_norm);

    // Sticky latch updated on strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     inv_q_o <= 1'b0;
        else if (stb_i) inv_q_o <= inv_next_o;
    end

    // R10: once inverted, stays inverted until reset
    p_latch_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q_o |=> inv_q_o);

endmodule

// File: rtl/rsm_fault_map.sv
// Fault availability map.
// Translates the fault descriptor into the side conditions still producible
// on the source and return sides of the active diagonal. Faults on the
// idle diagonal leave everything available.
module rsm_fault_map
    import rsm_pkg::*;
(
    input  logic        inv_i,
    input  logic        flt_vld_i,
    input  logic [2:0]  flt_idx_i,
    input  logic        flt_open_i,
    output side_avail_t src_av_o,
    output side_avail_t ret_av_o
);
    // Restrictions on one side given its outer and inner switch positions
    function automatic side_avail_t avail_of(input logic vld, input logic [2:0] idx,
                                             input logic opn, input int unsigned o_i,
                                             input int unsigned i_i);
        side_avail_t a;
        a.off_ok   = 1'b1;
        a.clamp_ok = 1'b1;
        a.full_ok  = 1'b1;
        if (vld) begin
            if (idx == 3'(o_i)) begin
                if (opn) a.full_ok  = 1'b0;
                else     a.clamp_ok = 1'b0;
            end else if (idx == 3'(i_i)) begin
                if (opn) begin
                    a.full_ok  = 1'b0;
                    a.clamp_ok = 1'b0;
                end else begin
                    a.off_ok   = 1'b0;
                end
            end
        end
        return a;
    endfunction

    // Pick the switch positions of the active diagonal and map the fault
    always_comb begin
        if (inv_i) begin
            src_av_o = avail_of(flt_vld_i, flt_idx_i, flt_open_i, I_SRC_OUT, I_SRC_IN);
            ret_av_o = avail_of(flt_vld_i, flt_idx_i, flt_open_i, I_RET_OUT, I_RET_IN);
        end else begin
            src_av_o = avail_of(flt_vld_i, flt_idx_i, flt_open_i, N_SRC_OUT, N_SRC_IN);
            ret_av_o = avail_of(flt_vld_i, flt_idx_i, flt_open_i, N_RET_OUT, N_RET_IN);
        end
    end

endmodule

// File: rtl/rsm_state_sel.sv
// Redundant state selector.
// Lists the side-condition pairs that produce the requested level, ordered
// by balancing preference, and takes the first one the fault map allows.
// Expects a saturated level in -2..+2. pref_i = 1 asks to lower the
// upper capacitor relative to the lower one.
module rsm_state_sel
    import rsm_pkg::*;
#(
    parameter int NCAND = 3
) (
    input  logic [2:0]  lvl_i,
    input  logic        pref_i,
    input  side_avail_t src_av_i,
    input  side_avail_t ret_av_i,
    output side_e       src_o,
    output side_e       ret_o,
    output logic        ok_o
);
    side_e cs [NCAND];
    side_e cr [NCAND];
    logic  cv [NCAND];

    // Build the ordered candidate list for the requested level
    always_comb begin
        for (int i = 0; i < NCAND; i++) begin
            cs[i] = SIDE_OFF;
            cr[i] = SIDE_OFF;
            cv[i] = 1'b0;
        end
        case (lvl_i)
            3'b010: begin
                cs[0] = SIDE_FULL;  cr[0] = SIDE_FULL;  cv[0] = 1'b1;
            end
            3'b001: begin
                cs[0] = pref_i ? SIDE_FULL  : SIDE_CLAMP;
                cr[0] = pref_i ? SIDE_CLAMP : SIDE_FULL;
                cs[1] = pref_i ? SIDE_CLAMP : SIDE_FULL;
                cr[1] = pref_i ? SIDE_FULL  : SIDE_CLAMP;
                cv[0] = 1'b1; cv[1] = 1'b1;
            end
            3'b000: begin
                cs[0] = SIDE_CLAMP; cr[0] = SIDE_CLAMP; cv[0] = 1'b1;
                cs[1] = SIDE_FULL;  cr[1] = SIDE_OFF;   cv[1] = 1'b1;
                cs[2] = SIDE_OFF;   cr[2] = SIDE_FULL;  cv[2] = 1'b1;
            end
            3'b111: begin
                cs[0] = pref_i ? SIDE_OFF   : SIDE_CLAMP;
                cr[0] = pref_i ? SIDE_CLAMP : SIDE_OFF;
                cs[1] = pref_i ? SIDE_CLAMP : SIDE_OFF;
                cr[1] = pref_i ? SIDE_OFF   : SIDE_CLAMP;
                cv[0] = 1'b1; cv[1] = 1'b1;
            end
            3'b110: begin
                cs[0] = SIDE_OFF;   cr[0] = SIDE_OFF;   cv[0] = 1'b1;
            end
            default: ;
        endcase
    end

    // Take the first candidate both sides can still produce
    always_comb begin
        src_o = SIDE_OFF;
        ret_o = SIDE_OFF;
        ok_o  = 1'b0;
        for (int i = NCAND - 1; i >= 0; i--) begin
            if (cv[i] && side_ok(cs[i], src_av_i) && side_ok(cr[i], ret_av_i)) begin
                src_o = cs[i];
                ret_o = cr[i];
                ok_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsm_top.sv
// Redundant-state modulator top.
// Saturates the level request, combines balance preference and current
// direction, selects a state allowed by the fault map on the active
// diagonal and registers the gate vector on the cycle strobe.
// Assumes dead time is added downstream.
module rsm_top
    import rsm_pkg::*;
#(
    parameter int VW = 10,
    parameter int DB = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb_i,
    input  logic [2:0]     lvl_i,
    input  logic [VW-1:0]  v_up_i,
    input  logic [VW-1:0]  v_lo_i,
    input  logic           cur_pos_i,
    input  logic           ft_en_i,
    input  logic           flt_vld_i,
    input  logic [2:0]     flt_idx_i,
    input  logic           flt_open_i,
    output logic [NSW-1:0] gate_o,
    output logic           degraded_o,
    output logic           exc_inv_o
);
    logic signed [2:0] lvl_s;
    logic [2:0]        lvl_sat;
    logic              pref_next;
    logic              inv_next;
    logic              eff_pref;
    side_avail_t       src_av, ret_av;
    side_e             src_s, ret_s;
    logic              sel_ok;
    logic [NSW-1:0]    gate_nxt;
    int unsigned       so_i, si_i, ro_i, ri_i;

    assign lvl_s = $signed(lvl_i);

    // Clamp out-of-range codes to the nearest full level
    always_comb begin
        if (lvl_s > 3'sb010)      lvl_sat = 3'b010;
        else if (lvl_s < 3'sb110) lvl_sat = 3'b110;
        else                      lvl_sat = lvl_i;
    end

    rsm_balance_pref #(.VW(VW), .DB(DB)) u_pref (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (stb_i),
        .v_up_i      (v_up_i),
        .v_lo_i      (v_lo_i),
        .pref_next_o (pref_next)
    );

    rsm_polarity u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb_i),
        .ft_en_i    (ft_en_i),
        .flt_vld_i  (flt_vld_i),
        .flt_idx_i  (flt_idx_i),
        .inv_next_o (inv_next),
        .inv_q_o    (exc_inv_o)
    );

    // Swap the balancing choice when current opposes the excitation direction
    assign eff_pref = (cur_pos_i ^ inv_next) ? pref_next : ~pref_next;

    rsm_fault_map u_fmap (
        .inv_i      (inv_next),
        .flt_vld_i  (flt_vld_i),
        .flt_idx_i  (flt_idx_i),
        .flt_open_i (flt_open_i),
        .src_av_o   (src_av),
        .ret_av_o   (ret_av)
    );

    rsm_state_sel u_sel (
        .lvl_i    (lvl_sat),
        .pref_i   (eff_pref),
        .src_av_i (src_av),
        .ret_av_i (ret_av),
        .src_o    (src_s),
        .ret_o    (ret_s),
        .ok_o     (sel_ok)
    );

    // Switch positions of the active diagonal
    always_comb begin
        so_i = inv_next ? I_SRC_OUT : N_SRC_OUT;
        si_i = inv_next ? I_SRC_IN  : N_SRC_IN;
        ro_i = inv_next ? I_RET_OUT : N_RET_OUT;
        ri_i = inv_next ? I_RET_IN  : N_RET_IN;
    end

    // Expand side conditions into per-switch gate commands
    for (genvar k = 0; k < NSW; k++) begin : g_gate
        assign gate_nxt[k] = sel_ok & (
              ((so_i == k) && (src_s == SIDE_FULL))
            | ((si_i == k) && (src_s != SIDE_OFF))
            | ((ro_i == k) && (ret_s == SIDE_FULL))
            | ((ri_i == k) && (ret_s != SIDE_OFF)));
    end

    // Register gate vector and degraded flag on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_o     <= '0;
            degraded_o <= 1'b0;
        end else if (stb_i) begin
            gate_o     <= gate_nxt;
            degraded_o <= ~sel_ok;
        end
    end

    // R1: reset leaves every gate low and both flags clear
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (gate_o == '0 && !degraded_o && !exc_inv_o));

    // R2: without a strobe nothing on the outputs moves
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(gate_o) && $stable(degraded_o) && $stable(exc_inv_o)));

    // R3: a producible full level drives four switches
    p_full_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && lvl_sat == 3'b010 && sel_ok) |=> ($countones(gate_o) == 4));

    // R9: degraded result leaves all gates low
    p_deg_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        degraded_o |-> (gate_o == '0));

    // R10: normal diagonal stays dark after reconfiguration
    p_norm_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_inv_o |-> ((gate_o & NORM_MASK) == '0));

    // R12: the two diagonals are never driven together
    p_diag_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(((gate_o & NORM_MASK) != '0) && ((gate_o & INV_MASK) != '0)));

endmodule

// File: tb/rsm_top_tb_top.sv
// Bench for rsm_top: vector table walk, then directed reset, hold and
// reconfiguration scenarios.
module rsm_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic [2:0] lvl = '0;
    logic [9:0] vup = '0;
    logic [9:0] vlo = '0;
    logic       cur = 1'b1;
    logic       ften = 1'b0;
    logic       fvld = 1'b0;
    logic [2:0] fidx = '0;
    logic       fopen = 1'b0;
    logic [7:0] gate;
    logic       deg;
    logic       inv;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rsm_top #(.VW(10), .DB(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb),
        .lvl_i      (lvl),
        .v_up_i     (vup),
        .v_lo_i     (vlo),
        .cur_pos_i  (cur),
        .ft_en_i    (ften),
        .flt_vld_i  (fvld),
        .flt_idx_i  (fidx),
        .flt_open_i (fopen),
        .gate_o     (gate),
        .degraded_o (deg),
        .exc_inv_o  (inv)
    );

    typedef struct packed {
        logic [2:0] lvl;
        logic [9:0] vup;
        logic [9:0] vlo;
        logic       cur;
        logic       fvld;
        logic [2:0] fidx;
        logic       fopen;
        logic [7:0] egate;
        logic       edeg;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{3'b010, 10'd500, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'hC3, 1'b0, 4'd3},  // R3 +2
        '{3'b110, 10'd500, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 -2
        '{3'b001, 10'd500, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'hC2, 1'b0, 4'd5},  // R5 reset pref
        '{3'b001, 10'd520, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h43, 1'b0, 4'd4},  // R4 upper high
        '{3'b001, 10'd505, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h43, 1'b0, 4'd5},  // R5 hold
        '{3'b111, 10'd505, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h40, 1'b0, 4'd5},  // R5 hold, -1
        '{3'b111, 10'd480, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h02, 1'b0, 4'd4},  // R4 lower high
        '{3'b001, 10'd480, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'hC2, 1'b0, 4'd4},  // R4
        '{3'b000, 10'd480, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h42, 1'b0, 4'd7},  // R7
        '{3'b001, 10'd520, 10'd500, 1'b0, 1'b0, 3'd0, 1'b0, 8'hC2, 1'b0, 4'd6},  // R6 swap
        '{3'b111, 10'd520, 10'd500, 1'b0, 1'b0, 3'd0, 1'b0, 8'h02, 1'b0, 4'd6},  // R6 swap
        '{3'b011, 10'd520, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'hC3, 1'b0, 4'd3},  // R3 saturate
        '{3'b100, 10'd520, 10'd500, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 saturate
        '{3'b001, 10'd520, 10'd500, 1'b1, 1'b1, 3'd0, 1'b1, 8'hC2, 1'b0, 4'd9},  // R9 S1 open
        '{3'b010, 10'd520, 10'd500, 1'b1, 1'b1, 3'd0, 1'b1, 8'h00, 1'b1, 4'd9},  // R9 degraded
        '{3'b111, 10'd520, 10'd500, 1'b1, 1'b1, 3'd1, 1'b0, 8'h02, 1'b0, 4'd8},  // R8 S2 short
        '{3'b110, 10'd520, 10'd500, 1'b1, 1'b1, 3'd1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 no off
        '{3'b000, 10'd520, 10'd500, 1'b1, 1'b1, 3'd1, 1'b0, 8'h42, 1'b0, 4'd8},  // R8
        '{3'b000, 10'd520, 10'd500, 1'b1, 1'b1, 3'd7, 1'b0, 8'h03, 1'b0, 4'd7},  // R7 fallback
        '{3'b001, 10'd520, 10'd500, 1'b1, 1'b1, 3'd6, 1'b1, 8'h00, 1'b1, 4'd8},  // R8 S7 open
        '{3'b010, 10'd520, 10'd500, 1'b1, 1'b1, 3'd2, 1'b1, 8'hC3, 1'b0, 4'd11}, // R11 idle diag
        '{3'b001, 10'd480, 10'd500, 1'b1, 1'b1, 3'd0, 1'b0, 8'h43, 1'b0, 4'd8},  // R8 S1 short
        '{3'b111, 10'd480, 10'd500, 1'b1, 1'b1, 3'd6, 1'b0, 8'h40, 1'b0, 4'd9}   // R9 S7 short
    };

    // Compare outputs against expectations and log any mismatch
    task automatic chk(input logic [7:0] eg, input logic ed, input logic ei, input int r);
        n_chk++;
        if (gate !== eg || deg !== ed || inv !== ei) begin
            n_err++;
            $display("FAIL R%0d: gate=%h deg=%b inv=%b expected gate=%h deg=%b inv=%b",
                     r, gate, deg, inv, eg, ed, ei);
        end
    endtask

    // Drive one strobed modulation cycle and wait until outputs settle
    task automatic step(input logic [2:0] l, input logic [9:0] u, input logic [9:0] d,
                        input logic c, input logic fe, input logic fv,
                        input logic [2:0] fi, input logic fo);
        @(negedge clk);
        lvl = l; vup = u; vlo = d; cur = c; ften = fe; fvld = fv; fidx = fi; fopen = fo;
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(8'h00, 1'b0, 1'b0, 1);  // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].lvl, VEC[i].vup, VEC[i].vlo, VEC[i].cur, 1'b0,
                 VEC[i].fvld, VEC[i].fidx, VEC[i].fopen);
            chk(VEC[i].egate, VEC[i].edeg, 1'b0, int'(VEC[i].req));
        end

        // R2: new request without strobe leaves outputs unchanged
        @(negedge clk);
        lvl = 3'b010; fvld = 1'b0;
        repeat (3) @(negedge clk);
        chk(8'h40, 1'b0, 1'b0, 2);

        // R11: fault on inverted-diagonal switch 4 does not reconfigure
        step(3'b010, 10'd500, 10'd500, 1'b1, 1'b1, 1'b1, 3'd3, 1'b1);
        chk(8'hC3, 1'b0, 1'b0, 11);

        // R10: open inner switch 2 with tolerance enabled inverts excitation
        step(3'b010, 10'd500, 10'd500, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1);
        chk(8'h3C, 1'b0, 1'b1, 10);
        // R10: stays inverted after the fault report and enable drop
        step(3'b010, 10'd500, 10'd500, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        chk(8'h3C, 1'b0, 1'b1, 10);
        // R12: inverted half levels and zero
        step(3'b001, 10'd520, 10'd500, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        chk(8'h34, 1'b0, 1'b1, 12);
        step(3'b111, 10'd480, 10'd500, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        chk(8'h20, 1'b0, 1'b1, 12);
        step(3'b000, 10'd480, 10'd500, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        chk(8'h24, 1'b0, 1'b1, 12);
        // R9: second fault on inverted source outer blocks full level
        step(3'b010, 10'd500, 10'd500, 1'b0, 1'b1, 1'b1, 3'd4, 1'b1);
        chk(8'h00, 1'b1, 1'b1, 9);

        // R1: reset clears latch and flags
        @(negedge clk);
        rst_n = 1'b0; fvld = 1'b0; ften = 1'b0;
        repeat (2) @(negedge clk);
        chk(8'h00, 1'b0, 1'b0, 1);
        rst_n = 1'b1;
        // R1: preference back to lower-high, in-band +1 picks source clamp
        step(3'b001, 10'd500, 10'd500, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        chk(8'hC2, 1'b0, 1'b0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule